// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns the system clock into the bit-level timing of a CAN node. A prescaler splits the clock into time quanta, and a segment sequencer walks each nominal bit through a one-quantum synchronisation segment, a propagation segment, a first phase segment and a second phase segment. At the end of the first phase segment it raises a one-cycle sample strobe and captures the bus level. At the end of the second phase segment it raises a one-cycle transmit strobe, which also marks the start of the next bit.

The received bus line passes through a two-flop synchroniser. A recessive-to-dominant (1 to 0) edge seen while the bus is flagged idle hard-synchronises the unit: the bit restarts. Once the bus is busy, a falling edge outside the synchronisation quantum resynchronises the bit by a bounded amount. An edge early in the bit stretches phase 1, and an edge in phase 2 cuts phase 2 short. This happens at most once per bit, and never while the node itself drives a dominant level. The segment lengths come from minus-one configuration fields. Illegal combinations are flagged, and the unit then stays halted.

Top module: `can_bit_timer`

## Requirements
- R1: `cfg_err` is 1 exactly when the settings are illegal. The settings are illegal when any of the following holds: prescaler field 0, phase-2 length (`cfg_phase2`+1) under 2, phase-2 length over phase-1 length (`cfg_phase1`+1), total bit length 1+(`cfg_prop`+1)+(`cfg_phase1`+1)+(`cfg_phase2`+1) outside 8..25, or jump length (`cfg_jump`+1) over the phase-1 length or over 4. The flag updates one clock after the settings change.
- R2: `cfg_err` reads 1 during reset. While `cfg_err` is 1, `tq_tick`, `sample_stb` and `tx_stb` stay 0.
- R3: `tq_tick` pulses once per quantum, and a quantum is `cfg_presc`+1 clocks.
- R4: With `bus_idle` high, a 1-to-0 change on `bus_rx` restarts the bit. The first new quantum starts on the third rising clock edge after the change, because of two synchroniser flops and one state register. The sample strobe then ends quantum 1+P+A of the bit, and the transmit strobe ends its last quantum.
- R5: `sample_val` holds the synchronised bus level captured at the latest sample strobe, and is 1 after reset.
- R6: With no resynchronising edge, a bit lasts exactly the total bit length in quanta. Consecutive transmit strobes are that many quanta apart.
- R7: A falling edge while `bus_idle` is low, in the propagation or phase-1 segment at quantum index q of the bit (0 is the synchronisation quantum), lengthens phase 1 by min(q, `cfg_jump`+1) quanta.
- R8: A falling edge in phase 2, at phase-2 quantum index j, shortens phase 2 by s = min(B-j, `cfg_jump`+1), where B is the phase-2 length. The bit then ends after quantum max(j, B-1-s) of phase 2.
- R9: No resynchronisation occurs for an edge in the synchronisation quantum, for any edge while `tx_dom` is 1, or for a 0-to-1 change.
- R10: `sample_stb` and `tx_stb` are single-cycle pulses and never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_presc | input | 7 | Quantum length minus one, in clocks |
| cfg_prop | input | 3 | Propagation segment length minus one, in quanta |
| cfg_phase1 | input | 3 | Phase-1 length minus one, in quanta |
| cfg_phase2 | input | 3 | Phase-2 length minus one, in quanta |
| cfg_jump | input | 2 | Resynchronisation jump limit minus one, in quanta |
| bus_rx | input | 1 | Raw received bus level (1 recessive, 0 dominant) |
| bus_idle | input | 1 | High when the bus is idle; enables hard synchronisation |
| tx_dom | input | 1 | High while this node drives a dominant level in the current bit |
| tq_tick | output | 1 | One-cycle pulse in the last clock of each quantum |
| sample_stb | output | 1 | One-cycle pulse at the sample point |
| sample_val | output | 1 | Bus level captured at the last sample point |
| tx_stb | output | 1 | One-cycle pulse at the end of each bit |
| cfg_err | output | 1 | Settings illegal; unit halted |

## Verification
The hardest situation to reach is a resynchronising edge that lands in a chosen quantum of a busy bit, in particular the quanta of phase 2 where the cut reaches the current quantum. The bench first hard-synchronises with a known edge, so that the bit grid is known to the clock. It then drops the idle flag, raises the line during the first bit, and drives a single falling edge at each clock position in turn across the whole second bit. It does this for several configurations, with the node's own dominant flag both clear and set. The expected sample and end-of-bit positions come from the quantum index of each edge.

// File: rtl/can_bt_pkg.sv
// Package: shared types for the CAN bit timing unit.
// Assumes: nothing beyond IEEE 1800-2017.
package can_bt_pkg;
    // Segment of the nominal bit currently being timed.
    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;

    // Legal bounds on the bit, in quanta.
    localparam int MIN_BIT_Q = 8;
    localparam int MAX_BIT_Q = 25;
    localparam int IPT_Q     = 2;
    localparam int JUMP_CAP  = 4;
endpackage

// File: rtl/can_bt_cfg_check.sv
// Module: can_bt_cfg_check
// Turns the minus-one setting fields into segment lengths and checks them
// against the legal bounds. The error flag is registered, and set in reset.
// Assumes: LEN_W >= JMP_W.
module can_bt_cfg_check
    import can_bt_pkg::*;
#(
    parameter int PRESC_W = 7,
    parameter int SEG_W   = 3,
    parameter int JUMP_W  = 2,
    localparam int LEN_W  = SEG_W + 1,
    localparam int JMP_W  = JUMP_W + 1,
    localparam int TOT_W  = LEN_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] presc,
    input  logic [SEG_W-1:0]   prop,
    input  logic [SEG_W-1:0]   ph1,
    input  logic [SEG_W-1:0]   ph2,
    input  logic [JUMP_W-1:0]  jump,
    output logic [LEN_W-1:0]   prop_len,
    output logic [LEN_W-1:0]   ph1_len,
    output logic [LEN_W-1:0]   ph2_len,
    output logic [JMP_W-1:0]   jmp_len,
    output logic               cfg_err
);
    logic [TOT_W-1:0] total_q;
    logic             legal;

    // Segment lengths in quanta from the minus-one fields.
    always_comb begin
        prop_len = LEN_W'(prop) + LEN_W'(1);
        ph1_len  = LEN_W'(ph1) + LEN_W'(1);
        ph2_len  = LEN_W'(ph2) + LEN_W'(1);
        jmp_len  = JMP_W'(jump) + JMP_W'(1);
        total_q  = TOT_W'(1) + TOT_W'(prop_len) + TOT_W'(ph1_len) + TOT_W'(ph2_len);
    end

    // Legality of the whole setting.
    always_comb begin
        legal = (presc != '0)
             && (ph2_len >= LEN_W'(IPT_Q))
             && (ph2_len <= ph1_len)
             && (total_q >= TOT_W'(MIN_BIT_Q))
             && (total_q <= TOT_W'(MAX_BIT_Q))
             && (LEN_W'(jmp_len) <= ph1_len)
             && (jmp_len <= JMP_W'(JUMP_CAP));
    end

    // Register the error flag; it is held high through reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b1;
        else        cfg_err <= !legal;
    end

    assert_zero_presc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(presc) == '0) |-> cfg_err);
    assert_short_ph2_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ph2) == '0) |-> cfg_err);
endmodule

// File: rtl/can_bt_rx_sync.sv
// Module: can_bt_rx_sync
// A synchroniser chain on the raw bus input, plus a falling-edge detector
// on the synchronised level. All stages reset to recessive.
// Assumes: STAGES >= 1.
module can_bt_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rx,
    output logic rx_s,
    output logic fedge
);
    logic [STAGES-1:0] stage;
    logic              rx_prev;

    genvar i;
    for (i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop takes the asynchronous line.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[0] <= 1'b1;
                else        stage[0] <= bus_rx;
            end
        end else begin : g_next
            // Later flops settle the level.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[i] <= 1'b1;
                else        stage[i] <= stage[i-1];
            end
        end
    end

    // Delayed copy of the synchronised level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_prev <= 1'b1;
        else        rx_prev <= stage[STAGES-1];
    end

    assign rx_s  = stage[STAGES-1];
    assign fedge = rx_prev & ~stage[STAGES-1];

    assert_single_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fedge |=> !fedge);
endmodule

// File: rtl/can_bt_prescaler.sv
// Module: can_bt_prescaler
// Counts clocks within a quantum and flags the last clock of each quantum.
// It is cleared while halted and on a hard synchronisation.
// Assumes: presc >= 1 whenever run is high.
module can_bt_prescaler #(
    parameter int PRESC_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    logic [PRESC_W-1:0] pcnt;

    // Clock counter within the current quantum.
    always_ff @(posedge clk) begin
        if (!rst_n)                pcnt <= '0;
        else if (!run || restart)  pcnt <= '0;
        else if (pcnt >= presc)    pcnt <= '0;
        else                       pcnt <= pcnt + PRESC_W'(1);
    end

    assign tick = run && (pcnt >= presc);

    assert_tick_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pcnt == '0));
endmodule

// File: rtl/can_bt_seq.sv
// Module: can_bt_seq
// Segment sequencer: moves through sync, propagation, phase 1 and phase 2
// on quantum ticks. It applies hard synchronisation and a bounded
// resynchronisation, and produces the sample and end-of-bit strobes.
// Assumes: segment lengths come from can_bt_cfg_check; run is low for
// illegal settings.
module can_bt_seq
    import can_bt_pkg::*;
#(
    parameter int LEN_W    = 4,
    parameter int JMP_W    = 3,
    localparam int QCNT_W  = LEN_W + 1,
    localparam int ERR_W   = LEN_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             hard_sync,
    input  logic             fedge,
    input  logic             bus_idle,
    input  logic             tx_dom,
    input  logic             rx_s,
    input  logic [LEN_W-1:0] prop_len,
    input  logic [LEN_W-1:0] ph1_len,
    input  logic [LEN_W-1:0] ph2_len,
    input  logic [JMP_W-1:0] jmp_len,
    output logic             sample_stb,
    output logic             tx_stb,
    output logic             sample_val
);
    seg_e              seg;
    logic [QCNT_W-1:0] qcnt;
    logic [JMP_W-1:0]  ext, shrink, ext_eff, shrink_eff;
    logic              done_rs;
    logic [ERR_W-1:0]  err_pre, err_ph2, jmp_e, q_e;
    logic              resync_ok, rs_pre, rs_ph2;
    logic              prop_done, ph1_done, ph2_done;

    function automatic logic [ERR_W-1:0] pick_min(input logic [ERR_W-1:0] a,
                                                  input logic [ERR_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    // Phase error of an edge and whether it may resynchronise this bit.
    always_comb begin
        q_e       = ERR_W'(qcnt);
        jmp_e     = ERR_W'(jmp_len);
        err_pre   = (seg == SEG_PROP) ? q_e + ERR_W'(1)
                                      : ERR_W'(prop_len) + q_e + ERR_W'(1);
        err_ph2   = ERR_W'(ph2_len) - q_e;
        resync_ok = run && fedge && !bus_idle && !tx_dom && !done_rs;
        rs_pre    = resync_ok && ((seg == SEG_PROP) || (seg == SEG_PH1));
        rs_ph2    = resync_ok && (seg == SEG_PH2);
    end

    // Adjustments that take effect in this cycle, and segment end tests.
    always_comb begin
        ext_eff    = rs_pre ? JMP_W'(pick_min(err_pre, jmp_e)) : ext;
        shrink_eff = rs_ph2 ? JMP_W'(pick_min(err_ph2, jmp_e)) : shrink;
        prop_done  = (q_e + ERR_W'(1)) >= ERR_W'(prop_len);
        ph1_done   = (q_e + ERR_W'(1)) >= (ERR_W'(ph1_len) + ERR_W'(ext_eff));
        ph2_done   = (q_e + ERR_W'(1) + ERR_W'(shrink_eff)) >= ERR_W'(ph2_len);
        sample_stb = run && tick && (seg == SEG_PH1) && ph1_done;
        tx_stb     = run && tick && (seg == SEG_PH2) && ph2_done;
    end

    // Segment state, quantum count and the resync bookkeeping of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || hard_sync) begin
            seg     <= SEG_SYNC;
            qcnt    <= '0;
            ext     <= '0;
            shrink  <= '0;
            done_rs <= 1'b0;
        end else begin
            if (rs_pre) begin
                ext     <= ext_eff;
                done_rs <= 1'b1;
            end
            if (rs_ph2) begin
                shrink  <= shrink_eff;
                done_rs <= 1'b1;
            end
            if (tick) begin
                case (seg)
                    SEG_SYNC: begin
                        seg  <= SEG_PROP;
                        qcnt <= '0;
                    end
                    SEG_PROP: begin
                        if (prop_done) begin
                            seg  <= SEG_PH1;
                            qcnt <= '0;
                        end else begin
                            qcnt <= qcnt + QCNT_W'(1);
                        end
                    end
                    SEG_PH1: begin
                        if (ph1_done) begin
                            seg  <= SEG_PH2;
                            qcnt <= '0;
                        end else begin
                            qcnt <= qcnt + QCNT_W'(1);
                        end
                    end
                    default: begin
                        if (ph2_done) begin
                            seg     <= SEG_SYNC;
                            qcnt    <= '0;
                            ext     <= '0;
                            shrink  <= '0;
                            done_rs <= 1'b0;
                        end else begin
                            qcnt <= qcnt + QCNT_W'(1);
                        end
                    end
                endcase
            end
        end
    end

    // Capture the bus level at the sample point.
    always_ff @(posedge clk) begin
        if (!rst_n)          sample_val <= 1'b1;
        else if (sample_stb) sample_val <= rx_s;
    end

    assert_hard_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hard_sync |=> (seg == SEG_SYNC) && (qcnt == '0));
    assert_ext_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seg == SEG_PH1) |-> (ext <= jmp_len));
    assert_shrink_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seg == SEG_PH2) |-> (shrink <= jmp_len));
    assert_own_dominant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fedge && tx_dom && (seg == SEG_PH1) && !tick) |=> (ext == $past(ext)));
    assert_sample_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);
endmodule

// File: rtl/can_bit_timer.sv
// Module: can_bit_timer (top)
// Bit timing unit for a CAN node. Chains the setting check, the input
// synchroniser, the quantum prescaler and the segment sequencer.
// Assumes: bus_idle and tx_dom come from the frame logic, synchronous to clk.
module can_bit_timer #(
    parameter int PRESC_W     = 7,
    parameter int SEG_W       = 3,
    parameter int JUMP_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] cfg_presc,
    input  logic [SEG_W-1:0]   cfg_prop,
    input  logic [SEG_W-1:0]   cfg_phase1,
    input  logic [SEG_W-1:0]   cfg_phase2,
    input  logic [JUMP_W-1:0]  cfg_jump,
    input  logic               bus_rx,
    input  logic               bus_idle,
    input  logic               tx_dom,
    output logic               tq_tick,
    output logic               sample_stb,
    output logic               sample_val,
    output logic               tx_stb,
    output logic               cfg_err
);
    localparam int LEN_W = SEG_W + 1;
    localparam int JMP_W = JUMP_W + 1;

    logic [LEN_W-1:0] prop_len, ph1_len, ph2_len;
    logic [JMP_W-1:0] jmp_len;
    logic             rx_s, fedge, run, hard_sync;

    can_bt_cfg_check #(.PRESC_W(PRESC_W), .SEG_W(SEG_W), .JUMP_W(JUMP_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .presc(cfg_presc), .prop(cfg_prop),
        .ph1(cfg_phase1), .ph2(cfg_phase2), .jump(cfg_jump),
        .prop_len(prop_len), .ph1_len(ph1_len), .ph2_len(ph2_len),
        .jmp_len(jmp_len), .cfg_err(cfg_err)
    );

    can_bt_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .bus_rx(bus_rx), .rx_s(rx_s), .fedge(fedge)
    );

    // Run only with legal settings; a falling edge on an idle bus restarts the bit.
    always_comb begin
        run       = !cfg_err;
        hard_sync = run && fedge && bus_idle;
    end

    can_bt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(hard_sync),
        .presc(cfg_presc), .tick(tq_tick)
    );

    can_bt_seq #(.LEN_W(LEN_W), .JMP_W(JMP_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tq_tick),
        .hard_sync(hard_sync), .fedge(fedge), .bus_idle(bus_idle),
        .tx_dom(tx_dom), .rx_s(rx_s), .prop_len(prop_len),
        .ph1_len(ph1_len), .ph2_len(ph2_len), .jmp_len(jmp_len),
        .sample_stb(sample_stb), .tx_stb(tx_stb), .sample_val(sample_val)
    );

    assert_quiet_on_error_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!tq_tick && !sample_stb && !tx_stb));
    assert_strobes_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_stb, tx_stb}));
endmodule

// File: tb/sim_can_bit_timer.sv
`timescale 1ns/1ps
module sim_can_bit_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cfg_presc = 7'd1;
    logic [2:0] cfg_prop = 3'd0, cfg_phase1 = 3'd0, cfg_phase2 = 3'd0;
    logic [1:0] cfg_jump = 2'd0;
    logic       bus_rx = 1'b1, bus_idle = 1'b1, tx_dom = 1'b0;
    logic       tq_tick, sample_stb, sample_val, tx_stb, cfg_err;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 1'b0;

    can_bit_timer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_presc(cfg_presc), .cfg_prop(cfg_prop),
        .cfg_phase1(cfg_phase1), .cfg_phase2(cfg_phase2), .cfg_jump(cfg_jump),
        .bus_rx(bus_rx), .bus_idle(bus_idle), .tx_dom(tx_dom),
        .tq_tick(tq_tick), .sample_stb(sample_stb), .sample_val(sample_val),
        .tx_stb(tx_stb), .cfg_err(cfg_err)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit legal_cfg(input int p, input int pr, input int a,
                                     input int b, input int j);
        int tot;
        tot = 1 + (pr + 1) + (a + 1) + (b + 1);
        return (p != 0) && (b + 1 >= 2) && (b <= a) && (tot >= 8) && (tot <= 25)
            && (j + 1 <= a + 1) && (j + 1 <= 4);
    endfunction

    task automatic do_reset(input int p, input int pr, input int a,
                            input int b, input int j);
        @(negedge clk);
        rst_n = 1'b0; bus_rx = 1'b1; bus_idle = 1'b1; tx_dom = 1'b0;
        cfg_presc = 7'(p); cfg_prop = 3'(pr); cfg_phase1 = 3'(a);
        cfg_phase2 = 3'(b); cfg_jump = 2'(j);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Hard sync, then one falling edge driven after rising edge m (0 = none).
    task automatic run_case(input int p, input int pr, input int a, input int b,
                            input int j, input int m, input bit txd);
        int T, L, Qs, J, p2, q, ext, s, qe, nq, exp_s2, exp_t2, lim;
        int ns, nt, ticks, val2;
        int sk[2];
        int tk[2];
        string req;
        T = p + 1; p2 = b + 1; J = j + 1;
        L = 1 + (pr + 1) + (a + 1) + p2;
        Qs = 1 + (pr + 1) + (a + 1);
        q = (m == 0) ? 0 : (m + 2 - 3 - L * T) / T;
        ext = 0; qe = L - 1;
        if (m == 0)          req = "R6";
        else if (txd || q == 0) req = "R9";
        else if (q < Qs) begin
            req = "R7"; ext = (q < J) ? q : J; qe = L - 1 + ext;
        end else begin
            req = "R8";
            s = ((p2 - (q - Qs)) < J) ? (p2 - (q - Qs)) : J;
            qe = Qs + p2 - 1 - s;
            if (qe < q) qe = q;
        end
        exp_s2 = 2 + (L + Qs + ext) * T;
        exp_t2 = 2 + (L + qe + 1) * T;
        nq = qe + 1;
        lim = 2 + 2 * L * T + 4 * T + 10;
        do_reset(p, pr, a, b, j);
        tx_dom = txd;
        repeat (5) @(negedge clk);
        bus_rx = 1'b0;
        ns = 0; nt = 0; ticks = 0; val2 = -1; sk[0] = -1; sk[1] = -1; tk[0] = -1; tk[1] = -1;
        for (int k = 1; k <= lim; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 3) bus_idle = 1'b0;
            if (m != 0 && k == Qs * T + 1) bus_rx = 1'b1;
            if (m != 0 && k == m) bus_rx = 1'b0;
            if (k >= 3) begin
                if (nt == 1 && tq_tick) ticks++;
                if (sample_stb && ns < 2) begin sk[ns] = k; ns++; end
                if (tx_stb && nt < 2) begin
                    tk[nt] = k; nt++;
                    if (nt == 1) check(sample_val == 1'b0, "R5", "bit1 sampled level", int'(sample_val), 0);
                    if (nt == 2) val2 = int'(sample_val);
                end
            end
        end
        check(sk[0] == 2 + Qs * T, "R4", "first sample cycle after hard sync", sk[0], 2 + Qs * T);
        check(tk[0] == 2 + L * T, "R4", "first end-of-bit cycle", tk[0], 2 + L * T);
        check(sk[1] == exp_s2, req, "second sample cycle", sk[1], exp_s2);
        check(tk[1] == exp_t2, req, "second end-of-bit cycle", tk[1], exp_t2);
        check(ticks == nq, "R3", "quanta in second bit", ticks, nq);
        check(val2 == ((m != 0 && q >= Qs) ? 1 : 0), "R5", "bit2 sampled level",
              val2, (m != 0 && q >= Qs) ? 1 : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++; n_checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        // Reset state (R2, R5)
        repeat (2) @(negedge clk);
        check(cfg_err == 1'b1, "R2", "cfg_err in reset", int'(cfg_err), 1);
        check(!tq_tick && !sample_stb && !tx_stb, "R2", "strobes in reset",
              int'({tq_tick, sample_stb, tx_stb}), 0);
        check(sample_val == 1'b1, "R5", "sample_val in reset", int'(sample_val), 1);

        // Exhaustive setting sweep with prescaler 1 (R1, R2)
        do_reset(1, 0, 7, 1, 0);
        for (int pr = 0; pr < 8; pr++)
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++)
                    for (int j = 0; j < 4; j++) begin
                        @(negedge clk);
                        cfg_prop = 3'(pr); cfg_phase1 = 3'(a);
                        cfg_phase2 = 3'(b); cfg_jump = 2'(j);
                        @(negedge clk);
                        check(cfg_err == !legal_cfg(1, pr, a, b, j), "R1", "cfg_err",
                              int'(cfg_err), int'(!legal_cfg(1, pr, a, b, j)));
                        if (cfg_err)
                            check(!tq_tick && !sample_stb && !tx_stb, "R2",
                                  "halted strobes", int'({tq_tick, sample_stb, tx_stb}), 0);
                    end
        // Prescaler bounds (R1)
        do_reset(0, 2, 3, 2, 1);
        repeat (3) @(negedge clk);
        check(cfg_err == 1'b1, "R1", "prescaler 0 flagged", int'(cfg_err), 1);
        check(!tq_tick, "R2", "no tick with prescaler 0", int'(tq_tick), 0);
        do_reset(127, 2, 3, 2, 1);
        repeat (3) @(negedge clk);
        check(cfg_err == 1'b0, "R1", "prescaler 127 legal", int'(cfg_err), 0);

        // Edge position sweeps over three small settings (R3..R9)
        run_case(1, 1, 3, 2, 1, 0, 1'b0);
        for (int m = 10 * 2 + 1; m <= 2 * 10 * 2; m++) run_case(1, 1, 3, 2, 1, m, 1'b0);
        for (int m = 10 * 2 + 1; m <= 2 * 10 * 2; m++) run_case(1, 1, 3, 2, 1, m, 1'b1);
        run_case(2, 2, 4, 3, 3, 0, 1'b0);
        for (int m = 13 * 3 + 1; m <= 2 * 13 * 3; m++) run_case(2, 2, 4, 3, 3, m, 1'b0);
        for (int m = 13 * 3 + 1; m <= 2 * 13 * 3; m += 2) run_case(2, 2, 4, 3, 3, m, 1'b1);
        for (int m = 8 * 2 + 1; m <= 2 * 8 * 2; m++) run_case(1, 0, 2, 2, 0, m, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule